// File: doc/BRIEF.md
# Serial Configuration Bitstream Frame Parser

This block takes a device configuration stream one bit at a time and splits it into its parts. It looks for a run of dummy ones followed by a fixed four-bit preamble and records the 24-bit length count that comes next. It then decodes the frames that follow. Frames are kept apart by high stop bits, and each one opens with a single low start bit.

There are four frame kinds. An optional identification frame carries a parity-enable setting and a 20-bit part identifier. An uncompressed frame carries a column address and a data word. A compressed frame carries only a column address. An end frame, which uses a fixed pattern, closes the configuration.

Each decoded address or data frame is handed out as one word on a valid/ready port. The word, its address and its compressed flag stay stable until the port accepts them. While a word is waiting, the block holds `bit_ready` low, so no new input bit is consumed. The word handshake and the intake of the next bit may both complete in the same cycle.

Top module: `cfg_frame_parser`

## Requirements
- R1: After a synchronous active-high reset, `frm_valid`, `id_valid`, `par_en`, `cfg_done` and `cfg_err` are low and `bit_ready` is high.
- R2: A header is at least 4 consecutive ones, then the bits 0,0,1,0, then a 24-bit length sent MSB first, which appears on `len_count`. A 0 after fewer than 4 ones, or a preamble bit that differs, restarts the header search without raising `cfg_err`.
- R3: The length is followed by at least 4 ones and then a 0 frame start bit. A 0 after fewer ones sets `cfg_err`.
- R4: After the start bit, each frame carries these fields in order: the P bit, the C bit, the odd parity bit, the even parity bit, and an 11-bit column address sent MSB first.
- R5: A frame with P=1, C=0 and an all-ones address is an ID frame. It carries a parity-enable bit, 43 reserved bits and a 20-bit part ID sent MSB first. At its end, `id_valid` rises, and `part_id` and `par_en` hold the received values.
- R6: A reserved bit of 1 in an ID frame sets `cfg_err`. So does a frame start that comes after fewer than 3 stop bits following an ID frame.
- R7: An uncompressed frame (P=1, C=0, address not all ones) continues with 2 alignment bits, whose values are ignored, then a write bit that must be 1, then 64 data bits sent MSB first. It yields one word with `frm_comp`=0. A write bit of 0 sets `cfg_err` and yields no word.
- R8: A compressed frame (P=1, C=1) ends after its address. It yields one word with `frm_comp`=1 and `frm_data` all zeros.
- R9: After an address or data frame, at least one stop bit must come before the next start bit. A start bit that comes at once sets `cfg_err`.
- R10: Parity is checked only while parity is enabled. The address bits and the data bits, in arrival order, are numbered from 0. The even parity bit must equal the XOR of the even-numbered bits, and the odd parity bit must equal the XOR of the odd-numbered bits. A mismatch sets `cfg_err` and yields no word.
- R11: The 16-bit end pattern 0010011111111111 sets `cfg_done`, and every bit after it is ignored. A frame with P=0 that differs from this pattern sets `cfg_err`.
- R12: `cfg_err` stays set until reset. After an error the parser searches for a new header, and it parses the frames after that header normally.
- R13: `frm_valid`, `col_addr`, `frm_data` and `frm_comp` hold until `frm_ready` is high. While `frm_valid` is high and `frm_ready` is low, `bit_ready` is low and no bit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial stream bit |
| bit_valid | input | 1 | bit_in holds a bit |
| bit_ready | output | 1 | Parser takes the bit this cycle |
| frm_valid | output | 1 | A frame word is waiting |
| frm_ready | input | 1 | Consumer accepts the frame word |
| col_addr | output | 11 | Column address of the word |
| frm_data | output | 64 | Data of the word (zero if compressed) |
| frm_comp | output | 1 | Word came from a compressed frame |
| len_count | output | 24 | Captured length count |
| part_id | output | 20 | Part identifier from the ID frame |
| id_valid | output | 1 | An ID frame was received |
| par_en | output | 1 | Parity checking enabled |
| cfg_done | output | 1 | End frame seen |
| cfg_err | output | 1 | Sticky format error |

## Verification
Two events can land on the same clock edge: the consumer takes a waiting word, and the parser takes the stop bit that was stalled behind it. The bench provokes this by holding `frm_ready` low after a data frame, with a stop bit offered. It checks that `bit_ready` stays low and that the word stays put. It then raises `frm_ready` while the bit is still offered. The bench judges that both were taken together by sending a compressed frame straight after, with no further stop bit. This frame parses without error only if the stalled stop bit was consumed on that same edge.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  typedef enum logic [3:0] {
    S_HUNT, S_PRE, S_LEN, S_TRAIL, S_FHDR, S_IDF,
    S_ALIGN, S_WBIT, S_DATA, S_STOP, S_DONE
  } pst_e;

  localparam int FLAG_W = 4; // P, C, odd parity, even parity

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfgp_runcnt.sv
module cfgp_runcnt #(
  parameter int MAXV = 4,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_o <= '0;
    else if (en) begin
      if (!bit_i)          cnt_o <= '0;
      else if (cnt_o != W'(MAXV)) cnt_o <= cnt_o + W'(1);
    end
  end
endmodule

// File: rtl/cfgp_shreg.sv
module cfgp_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic         bit_i,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= {q[W-2:0], bit_i};
  end
endmodule

// File: rtl/cfgp_parity.sv
module cfgp_parity (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic bit_i,
  output logic po_nx,
  output logic pe_nx
);
  logic pos_q, po_q, pe_q;

  // Values including the bit presented this cycle.
  always_comb begin
    po_nx = po_q ^ (en & bit_i & pos_q);
    pe_nx = pe_q ^ (en & bit_i & ~pos_q);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos_q <= 1'b0;
      po_q  <= 1'b0;
      pe_q  <= 1'b0;
    end else if (en) begin
      pos_q <= ~pos_q;
      po_q  <= po_nx;
      pe_q  <= pe_nx;
    end
  end
endmodule

// File: rtl/cfg_frame_parser.sv
module cfg_frame_parser
  import cfgp_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ALIGN_W     = 2,
  parameter int ADDR_W      = 11,
  parameter int LEN_W       = 24,
  parameter int ID_W        = 20,
  parameter int RSV_W       = 43,
  parameter int HDR_ONES    = 4,
  parameter int ID_STOP_MIN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_in,
  input  logic              bit_valid,
  output logic              bit_ready,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [ADDR_W-1:0] col_addr,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_comp,
  output logic [LEN_W-1:0]  len_count,
  output logic [ID_W-1:0]   part_id,
  output logic              id_valid,
  output logic              par_en,
  output logic              cfg_done,
  output logic              cfg_err
);
  localparam int HDR_W   = FLAG_W + ADDR_W;
  localparam int IDF_W   = 1 + RSV_W + ID_W;
  localparam int MAXF    = imax(imax(imax(LEN_W, IDF_W), imax(DATA_W, HDR_W)), ALIGN_W);
  localparam int CW      = $clog2(MAXF + 1);
  localparam int RUN_MAX = imax(HDR_ONES, ID_STOP_MIN);
  localparam int RW      = $clog2(RUN_MAX + 1);

  localparam logic [CW-1:0] LEN_LAST   = CW'(LEN_W - 1);
  localparam logic [CW-1:0] HDR_LAST   = CW'(HDR_W - 1);
  localparam logic [CW-1:0] IDF_LAST   = CW'(IDF_W - 1);
  localparam logic [CW-1:0] DATA_LAST  = CW'(DATA_W - 1);
  localparam logic [CW-1:0] ALIGN_LAST = (ALIGN_W > 0) ? CW'(ALIGN_W - 1) : '0;
  localparam logic [CW-1:0] ADDR_FIRST = CW'(FLAG_W);
  localparam logic [CW-1:0] RSV_LAST   = CW'(RSV_W);
  localparam logic [CW-1:0] ID_FIRST   = CW'(RSV_W + 1);

  pst_e              st_q;
  logic [CW-1:0]     cnt_q;
  logic [HDR_W-2:0]  hdr_q;
  logic [HDR_W-1:0]  hdr_nx;
  logic [ADDR_W-1:0] addr_q;
  logic              op_q, ep_q, fv_q, comp_q, done_q, err_q, idv_q, pen_q, idstop_q;
  logic [RW-1:0]     run_q, stop_need;
  logic              take, fstart, run_clr, par_en_in, po_nx, pe_nx;
  logic              h_p, h_c, h_op, h_ep, addr_ones, par_ok_c, par_ok_d;
  logic [ADDR_W-1:0] h_addr;

  assign bit_ready = !(fv_q && !frm_ready);
  assign take      = bit_valid && bit_ready;
  assign stop_need = idstop_q ? RW'(ID_STOP_MIN) : RW'(1);

  assign hdr_nx    = {hdr_q, bit_in};
  assign h_p       = hdr_nx[HDR_W-1];
  assign h_c       = hdr_nx[HDR_W-2];
  assign h_op      = hdr_nx[HDR_W-3];
  assign h_ep      = hdr_nx[HDR_W-4];
  assign h_addr    = hdr_nx[ADDR_W-1:0];
  assign addr_ones = &h_addr;

  assign fstart = take && !bit_in &&
                  ((st_q == S_TRAIL && run_q >= RW'(HDR_ONES)) ||
                   (st_q == S_STOP  && run_q >= stop_need));

  assign run_clr = take && ((st_q == S_LEN  && cnt_q == LEN_LAST) ||
                            (st_q == S_IDF  && cnt_q == IDF_LAST) ||
                            (st_q == S_FHDR && cnt_q == HDR_LAST) ||
                            (st_q == S_DATA && cnt_q == DATA_LAST));

  assign par_en_in = take && ((st_q == S_FHDR && cnt_q >= ADDR_FIRST) || st_q == S_DATA);
  assign par_ok_c  = !pen_q || (po_nx == h_op && pe_nx == h_ep);
  assign par_ok_d  = !pen_q || (po_nx == op_q && pe_nx == ep_q);

  cfgp_runcnt #(.MAXV(RUN_MAX)) i_run (
    .clk(clk), .rst(rst), .clr(run_clr), .en(take), .bit_i(bit_in), .cnt_o(run_q)
  );

  cfgp_shreg #(.W(LEN_W)) i_len (
    .clk(clk), .rst(rst), .clr(1'b0), .en(take && st_q == S_LEN),
    .bit_i(bit_in), .q(len_count)
  );

  cfgp_shreg #(.W(ID_W)) i_id (
    .clk(clk), .rst(rst), .clr(1'b0),
    .en(take && st_q == S_IDF && cnt_q >= ID_FIRST),
    .bit_i(bit_in), .q(part_id)
  );

  cfgp_shreg #(.W(DATA_W)) i_data (
    .clk(clk), .rst(rst), .clr(fstart), .en(take && st_q == S_DATA),
    .bit_i(bit_in), .q(frm_data)
  );

  cfgp_parity i_par (
    .clk(clk), .rst(rst), .clr(fstart), .en(par_en_in), .bit_i(bit_in),
    .po_nx(po_nx), .pe_nx(pe_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) hdr_q <= '0;
    else if (take && st_q == S_FHDR) hdr_q <= hdr_nx[HDR_W-2:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_HUNT;
      cnt_q    <= '0;
      addr_q   <= '0;
      op_q     <= 1'b0;
      ep_q     <= 1'b0;
      fv_q     <= 1'b0;
      comp_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      idv_q    <= 1'b0;
      pen_q    <= 1'b0;
      idstop_q <= 1'b0;
    end else begin
      if (fv_q && frm_ready) fv_q <= 1'b0;
      if (take) begin
        cnt_q <= cnt_q + CW'(1);
        unique case (st_q)
          S_HUNT: if (!bit_in && run_q >= RW'(HDR_ONES)) begin
            st_q  <= S_PRE;
            cnt_q <= '0;
          end
          S_PRE: begin
            if (bit_in != (cnt_q == CW'(1))) st_q <= S_HUNT;
            else if (cnt_q == CW'(2)) begin
              st_q  <= S_LEN;
              cnt_q <= '0;
            end
          end
          S_LEN: if (cnt_q == LEN_LAST) st_q <= S_TRAIL;
          S_TRAIL, S_STOP: if (!bit_in) begin
            if (fstart) begin
              st_q  <= S_FHDR;
              cnt_q <= '0;
            end else begin
              err_q <= 1'b1;
              st_q  <= S_HUNT;
            end
          end
          S_FHDR: if (cnt_q == HDR_LAST) begin
            cnt_q <= '0;
            if (!h_p) begin
              if (h_c && !h_op && !h_ep && addr_ones) begin
                done_q <= 1'b1;
                st_q   <= S_DONE;
              end else begin
                err_q <= 1'b1;
                st_q  <= S_HUNT;
              end
            end else if (!h_c && addr_ones) begin
              st_q <= S_IDF;
            end else if (h_c) begin
              if (par_ok_c) begin
                fv_q     <= 1'b1;
                comp_q   <= 1'b1;
                addr_q   <= h_addr;
                idstop_q <= 1'b0;
                st_q     <= S_STOP;
              end else begin
                err_q <= 1'b1;
                st_q  <= S_HUNT;
              end
            end else begin
              addr_q <= h_addr;
              op_q   <= h_op;
              ep_q   <= h_ep;
              st_q   <= (ALIGN_W > 0) ? S_ALIGN : S_WBIT;
            end
          end
          S_ALIGN: if (cnt_q == ALIGN_LAST) st_q <= S_WBIT;
          S_WBIT: begin
            cnt_q <= '0;
            if (bit_in) st_q <= S_DATA;
            else begin
              err_q <= 1'b1;
              st_q  <= S_HUNT;
            end
          end
          S_DATA: if (cnt_q == DATA_LAST) begin
            if (par_ok_d) begin
              fv_q     <= 1'b1;
              comp_q   <= 1'b0;
              idstop_q <= 1'b0;
              st_q     <= S_STOP;
            end else begin
              err_q <= 1'b1;
              st_q  <= S_HUNT;
            end
          end
          S_IDF: begin
            if (cnt_q == '0) pen_q <= bit_in;
            else if (cnt_q <= RSV_LAST && bit_in) begin
              err_q <= 1'b1;
              st_q  <= S_HUNT;
            end
            if (cnt_q == IDF_LAST) begin
              idv_q    <= 1'b1;
              idstop_q <= 1'b1;
              st_q     <= S_STOP;
            end
          end
          S_DONE: ;
          default: st_q <= S_HUNT;
        endcase
      end
    end
  end

  assign frm_valid = fv_q;
  assign col_addr  = addr_q;
  assign frm_comp  = comp_q;
  assign id_valid  = idv_q;
  assign par_en    = pen_q;
  assign cfg_done  = done_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/cfgp_checker.sv
module cfgp_checker #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_ready,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic [ADDR_W-1:0] col_addr,
  input logic [DATA_W-1:0] frm_data,
  input logic              frm_comp,
  input logic              id_valid,
  input logic              cfg_done,
  input logic              cfg_err
);
  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!frm_valid && !cfg_err && !cfg_done && !id_valid && bit_ready));

  p_hold_word_r13: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && !frm_ready) |=>
      (frm_valid && $stable(col_addr) && $stable(frm_data) && $stable(frm_comp)));

  p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);

  p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_done |=> cfg_done);

  p_quiet_after_done_r11: assert property (@(posedge clk) disable iff (rst)
    cfg_done |-> !$rose(frm_valid));

  p_comp_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (frm_valid && frm_comp) |-> (frm_data == '0));

  p_id_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    id_valid |=> id_valid);
endmodule

bind cfg_frame_parser cfgp_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .bit_ready(bit_ready), .frm_valid(frm_valid),
  .frm_ready(frm_ready), .col_addr(col_addr), .frm_data(frm_data),
  .frm_comp(frm_comp), .id_valid(id_valid), .cfg_done(cfg_done), .cfg_err(cfg_err)
);

// File: tb/test_cfg_frame_parser.sv
module test_cfg_frame_parser;
  localparam int CLK_P = 10;

  logic        clk = 1'b0, rst = 1'b1, bit_in = 1'b1, bit_valid = 1'b0, frm_ready = 1'b1;
  logic        bit_ready, frm_valid, frm_comp, id_valid, par_en, cfg_done, cfg_err;
  logic [10:0] col_addr;
  logic [63:0] frm_data;
  logic [23:0] len_count;
  logic [19:0] part_id;

  int n_chk = 0, n_err = 0, w_cnt = 0;
  logic [10:0] w_addr;
  logic [63:0] w_data;
  logic        w_comp;

  always #(CLK_P/2) clk = ~clk;

  cfg_frame_parser i_cfg_frame_parser (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .col_addr(col_addr), .frm_data(frm_data),
    .frm_comp(frm_comp), .len_count(len_count), .part_id(part_id), .id_valid(id_valid),
    .par_en(par_en), .cfg_done(cfg_done), .cfg_err(cfg_err)
  );

  // Record each accepted word.
  always @(posedge clk) begin
    if (!rst && frm_valid && frm_ready) begin
      w_cnt  <= w_cnt + 1;
      w_addr <= col_addr;
      w_data <= frm_data;
      w_comp <= frm_comp;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_valid = 1'b1;
    do @(posedge clk); while (!bit_ready);
    #1 bit_valid = 1'b0;
  endtask

  task automatic send_vec(input logic [63:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send_bit(1'b1);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_valid = 1'b0; frm_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [1:0] calc_par(input logic [10:0] a, input logic [63:0] d, input bit with_d);
    logic o = 1'b0, e = 1'b0;
    int idx = 0;
    for (int i = 10; i >= 0; i--) begin
      if (idx % 2 == 1) o ^= a[i]; else e ^= a[i];
      idx++;
    end
    if (with_d) for (int i = 63; i >= 0; i--) begin
      if (idx % 2 == 1) o ^= d[i]; else e ^= d[i];
      idx++;
    end
    return {o, e};
  endfunction

  task automatic send_header(input logic [23:0] len, input int lead, input int trail);
    send_ones(lead);
    send_vec(64'b0010, 4);
    send_vec({40'd0, len}, 24);
    send_ones(trail);
  endtask

  task automatic send_dframe(input logic [10:0] a, input logic [63:0] d, input logic wb, input bit flip);
    logic [1:0] p = calc_par(a, d, 1'b1);
    if (flip) p[0] = ~p[0];
    send_vec({59'd0, 5'b01000 | {3'b0, p}}, 5);
    send_vec({53'd0, a}, 11);
    send_vec(64'd0, 2);
    send_bit(wb);
    send_vec(d, 64);
  endtask

  task automatic send_cframe(input logic [10:0] a, input bit flip);
    logic [1:0] p = calc_par(a, 64'd0, 1'b0);
    if (flip) p[0] = ~p[0];
    send_vec({59'd0, 5'b01100 | {3'b0, p}}, 5);
    send_vec({53'd0, a}, 11);
  endtask

  task automatic send_idframe(input logic pen, input logic [19:0] id, input bit bad_rsv);
    send_vec(64'b01000, 5);
    send_ones(11);
    send_bit(pen);
    for (int i = 0; i < 43; i++) send_bit(bad_rsv && i == 20);
    send_vec({44'd0, id}, 20);
  endtask

  task automatic send_end();
    send_vec(64'b0010011111111111, 16);
    send_ones(8);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    check("R1 frm_valid", frm_valid, 0);
    check("R1 cfg_err",   cfg_err,   0);
    check("R1 cfg_done",  cfg_done,  0);
    check("R1 id_valid",  id_valid,  0);
    check("R1 par_en",    par_en,    0);
    check("R1 bit_ready", bit_ready, 1);
  endtask

  task automatic t_basic();
    int base;
    do_reset();
    send_header(24'h123456, 4, 4);
    settle();
    check("R2 len_count", len_count, 24'h123456);
    send_idframe(1'b0, 20'hABCDE, 1'b0);
    send_ones(3);
    settle();
    check("R5 id_valid", id_valid, 1);
    check("R5 part_id", part_id, 20'hABCDE);
    check("R5 par_en", par_en, 0);
    base = w_cnt;
    send_dframe(11'h155, 64'hDEADBEEF01234567, 1'b1, 1'b0);
    send_ones(2);
    settle();
    check("R7 word count", w_cnt, base + 1);
    check("R4 address", w_addr, 11'h155);
    check("R7 data", w_data, 64'hDEADBEEF01234567);
    check("R7 comp flag", w_comp, 0);
    send_cframe(11'h2AA, 1'b0);
    send_ones(1);
    settle();
    check("R8 word count", w_cnt, base + 2);
    check("R8 address", w_addr, 11'h2AA);
    check("R8 comp flag", w_comp, 1);
    check("R8 data zero", w_data, 0);
    // Parity disabled: wrong parity is accepted.
    send_dframe(11'h003, 64'h1, 1'b1, 1'b1);
    send_ones(1);
    settle();
    check("R10 no check when disabled", w_cnt, base + 3);
    check("R10 no error when disabled", cfg_err, 0);
    send_end();
    settle();
    check("R11 done", cfg_done, 1);
    send_vec(64'h0F0F, 16);
    send_dframe(11'h010, 64'h5, 1'b1, 1'b0);
    settle();
    check("R11 ignored after done: err", cfg_err, 0);
    check("R11 ignored after done: words", w_cnt, base + 3);
  endtask

  task automatic t_hunt();
    do_reset();
    send_vec(64'b110, 3);          // 0 after only two ones
    send_vec(64'b1111000, 7);      // preamble third bit wrong
    send_header(24'hA5A5A5, 12, 8);
    send_dframe(11'h001, 64'hCAFE, 1'b1, 1'b0);
    send_ones(8);
    settle();
    check("R2 restart without error", cfg_err, 0);
    check("R2 len after restart", len_count, 24'hA5A5A5);
    check("R2 frame after restart", w_data, 64'hCAFE);
  endtask

  task automatic t_trail_short();
    do_reset();
    send_header(24'h000010, 4, 2);
    send_bit(1'b0);
    settle();
    check("R3 short trailer error", cfg_err, 1);
  endtask

  task automatic t_id_errors();
    int base;
    do_reset();
    send_header(24'h1, 4, 4);
    send_idframe(1'b0, 20'h12345, 1'b1);
    settle();
    check("R6 reserved bit error", cfg_err, 1);
    // Recovery under a new header; error stays set.
    base = w_cnt;
    send_ones(4);
    send_header(24'h2, 4, 4);
    send_dframe(11'h077, 64'h77, 1'b1, 1'b0);
    send_ones(1);
    settle();
    check("R12 parse after error", w_cnt, base + 1);
    check("R12 error sticky", cfg_err, 1);
    do_reset();
    send_header(24'h3, 4, 4);
    send_idframe(1'b0, 20'h54321, 1'b0);
    send_ones(2);
    send_cframe(11'h001, 1'b0);
    settle();
    check("R6 short ID stop error", cfg_err, 1);
  endtask

  task automatic t_wbit_stop();
    int base;
    do_reset();
    base = w_cnt;
    send_header(24'h4, 4, 4);
    send_dframe(11'h100, 64'h9, 1'b0, 1'b0);
    settle();
    check("R7 missing write bit error", cfg_err, 1);
    check("R7 no word on bad write bit", w_cnt, base);
    do_reset();
    send_header(24'h5, 4, 4);
    send_cframe(11'h020, 1'b0);
    send_bit(1'b0);
    settle();
    check("R9 missing stop bit error", cfg_err, 1);
  endtask

  task automatic t_parity();
    int base;
    do_reset();
    send_header(24'h6, 4, 4);
    send_idframe(1'b1, 20'h0F0F0, 1'b0);
    send_ones(8);
    base = w_cnt;
    send_dframe(11'h5A3, 64'h0123456789ABCDEF, 1'b1, 1'b0);
    send_ones(1);
    send_cframe(11'h3C5, 1'b0);
    send_ones(1);
    settle();
    check("R10 par_en set", par_en, 1);
    check("R10 good parity words", w_cnt, base + 2);
    check("R10 good parity no error", cfg_err, 0);
    send_dframe(11'h5A3, 64'h0123456789ABCDEF, 1'b1, 1'b1);
    send_ones(1);
    settle();
    check("R10 bad parity error", cfg_err, 1);
    check("R10 bad parity no word", w_cnt, base + 2);
  endtask

  task automatic t_end_bad();
    do_reset();
    send_header(24'h7, 4, 4);
    send_vec(64'b0011011111111111, 16);
    settle();
    check("R11 wrong end pattern error", cfg_err, 1);
    check("R11 not done", cfg_done, 0);
  endtask

  task automatic t_backpressure();
    int base;
    do_reset();
    send_header(24'h8, 4, 4);
    base = w_cnt;
    frm_ready = 1'b0;
    send_dframe(11'h0AB, 64'hFEEDFACE00C0FFEE, 1'b1, 1'b0);
    @(negedge clk);
    bit_in = 1'b1; bit_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R13 stall bit_ready", bit_ready, 0);
    check("R13 word held", frm_valid, 1);
    check("R13 data held", frm_data, 64'hFEEDFACE00C0FFEE);
    check("R13 no accept", w_cnt, base);
    frm_ready = 1'b1;
    #1 check("R13 ready released", bit_ready, 1);
    @(posedge clk);
    #1 bit_valid = 1'b0;
    @(negedge clk);
    check("R13 word taken", w_cnt, base + 1);
    check("R13 valid dropped", frm_valid, 0);
    send_cframe(11'h0CD, 1'b0);   // no extra stop bit: the stalled one counts
    send_ones(1);
    settle();
    check("R13 same-cycle bit consumed", cfg_err, 0);
    check("R13 following frame", w_addr, 11'h0CD);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_hunt();
    t_trail_short();
    t_id_errors();
    t_wbit_stop();
    t_parity();
    t_end_bad();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule